// File: doc/BRIEF.md
# Multi-Channel Reloading Timer Unit

This block holds three independent 32-bit down-counting timer channels behind a simple single-cycle register port. Each channel has its own prescaler, fed from the common peripheral clock. The prescaler produces a count tick every 4, 16, 64 or 256 clock cycles. On each tick the channel's counter steps down by one.

When a tick finds the counter at zero, the channel underflows. The counter then takes the value held in the channel's constant register, and a sticky underflow flag is raised. A reload value of zero makes a one-shot timer. A reload value of all ones, with the counter loaded the same way, makes a free-running 32-bit time base. Each channel drives its own interrupt line, which is high while the flag and the channel's interrupt enable are both set.

A shared start register gates all channels. Clearing a channel's start bit freezes its count. Setting the bit again restarts that channel's prescaler from the beginning of a period.

Top module: `mtimer_unit`

## Requirements
- R1: After reset the start register reads 0, every count and constant register reads 0xFFFFFFFF, every control register reads 0, and all interrupt outputs are low.
- R2: The word address is {slot, reg}, with slot in the upper bits and reg in the two low bits. Slot 0, reg 0 is the start register. Slot c+1 belongs to channel c, where reg 0 is the count, reg 1 is the constant and reg 2 is the control register. Reads are combinational from the address. Writes take effect at the clock edge where bus_sel and bus_wr are both high. The control register reads back the select field in bits [2:0], the interrupt enable in bit 5 and the underflow flag in bit 8, with all other bits 0.
- R3: Writing the count register loads it directly. Each count tick lowers a nonzero count by one.
- R4: The tick period is 4 << (2*sel) clock cycles, where sel is control bits [2:0], for sel 0 to 3. Select values 4 to 7 divide by 4.
- R5: A tick that arrives while the count is 0 loads the constant value instead of decrementing, and sets the underflow flag (control bit 8).
- R6: With a constant of 0, the count stays at 0 after an underflow (one-shot use). With a constant of all ones, the count wraps from 0 to 0xFFFFFFFF and keeps counting down.
- R7: The underflow flag clears only when the control register is written with bit 8 at 0. Writing bit 8 as 1 leaves the flag unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: The interrupt output of channel c is high exactly while its underflow flag and its enable bit (control bit 5) are both 1.
- R9: Start register bit c enables channel c. While the bit is 0, the channel's count holds its value. Channels do not affect each other.
- R10: The prescaler restarts when its start bit goes from 0 to 1. The first count update happens exactly one full tick period after the clock edge that wrote the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Word address {slot, reg} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 3 | Per-channel interrupt, flag AND enable |

## Verification
A register write becomes visible in the read data one cycle later, at the edge where it is captured. The bench drives on the falling edge and reads 1 ns after it. The first count update after a start comes N edges after the start write, where N is the tick period, and an underflow from a load value L lands N*(L+1) edges after that write. The flag and the interrupt change at that same edge, so each check is taken half a cycle before the predicted edge and half a cycle after it. The collision and prescaler-restart tests place their writes on exactly the computed underflow edge, or on the edge just before it, so that an early or late tick is caught.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  localparam int REG_CNT     = 0;
  localparam int REG_CST     = 1;
  localparam int REG_CTL     = 2;
  localparam int CTL_IE_BIT  = 5;
  localparam int CTL_UNF_BIT = 8;
  localparam int PS_W        = 8;

  // last prescaler state before a tick: (4 << 2*sel) - 1, reserved selects act as 0
  function automatic logic [PS_W-1:0] ps_last(input logic [2:0] sel);
    logic [PS_W:0] span;
    if (sel > 3'd3) span = (PS_W+1)'(4);
    else            span = (PS_W+1)'(4) << (2 * sel);
    return PS_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/mtu_prescaler.sv
module mtu_prescaler
  import mtu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] last;

  assign last = ps_last(sel);
  // >= keeps a select change mid-period from stalling the divider
  assign tick = run && (div_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (!run || tick)  div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/mtu_channel.sv
module mtu_channel
  import mtu_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_cst,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cst,
  output logic [2:0]    sel,
  output logic          ie,
  output logic          flag,
  output logic [CW-1:0] ctl_rd
);
  logic unf;

  assign unf = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '1;
      cst <= '1;
    end else begin
      if (wr_cnt)    cnt <= wdata;
      else if (unf)  cnt <= cst;
      else if (tick) cnt <= cnt - 1'b1;
      if (wr_cst)    cst <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= '0;
      ie   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (wr_ctl) begin
        sel  <= wdata[2:0];
        ie   <= wdata[CTL_IE_BIT];
        flag <= (flag & wdata[CTL_UNF_BIT]) | unf;
      end else begin
        flag <= flag | unf;
      end
    end
  end

  always_comb begin
    ctl_rd              = '0;
    ctl_rd[2:0]         = sel;
    ctl_rd[CTL_IE_BIT]  = ie;
    ctl_rd[CTL_UNF_BIT] = flag;
  end
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import mtu_pkg::*;
#(
  parameter  int NCH = 3,
  parameter  int CW  = 32,
  localparam int SW  = $clog2(NCH + 1),
  localparam int AW  = SW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic [NCH-1:0] irq
);
  logic [SW-1:0]          slot;
  logic [1:0]             rsel;
  logic                   wen;
  logic [NCH-1:0]         start_q;
  logic [NCH-1:0]         tick_v;
  logic [NCH-1:0]         flag_v;
  logic [NCH-1:0]         ie_v;
  logic [NCH-1:0][CW-1:0] cnt_a;
  logic [NCH-1:0][CW-1:0] cst_a;
  logic [NCH-1:0][CW-1:0] ctl_a;

  assign slot = bus_addr[AW-1:2];
  assign rsel = bus_addr[1:0];
  assign wen  = bus_sel && bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)                                   start_q <= '0;
    else if (wen && slot == '0 && rsel == 2'd0)   start_q <= bus_wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [2:0] sel_c;
    logic       hit;

    assign hit = wen && (slot == SW'(c + 1));

    mtu_prescaler u_ps (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (start_q[c]),
      .sel   (sel_c),
      .tick  (tick_v[c])
    );

    mtu_channel #(.CW(CW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_v[c]),
      .wr_cnt (hit && rsel == 2'(REG_CNT)),
      .wr_cst (hit && rsel == 2'(REG_CST)),
      .wr_ctl (hit && rsel == 2'(REG_CTL)),
      .wdata  (bus_wdata),
      .cnt    (cnt_a[c]),
      .cst    (cst_a[c]),
      .sel    (sel_c),
      .ie     (ie_v[c]),
      .flag   (flag_v[c]),
      .ctl_rd (ctl_a[c])
    );

    assign irq[c] = flag_v[c] & ie_v[c];
  end

  always_comb begin
    bus_rdata = '0;
    if (slot == '0) begin
      if (rsel == 2'd0) bus_rdata[NCH-1:0] = start_q;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (slot == SW'(c + 1)) begin
          case (rsel)
            2'(REG_CNT): bus_rdata = cnt_a[c];
            2'(REG_CST): bus_rdata = cst_a[c];
            2'(REG_CTL): bus_rdata = ctl_a[c];
            default:     bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mtu_checker.sv
module mtu_checker #(
  parameter int NCH = 3,
  parameter int CW  = 32,
  parameter int AW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic [CW-1:0]          bus_wdata,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         run_v,
  input logic [NCH-1:0]         tick_v,
  input logic [NCH-1:0]         flag_v,
  input logic [NCH-1:0][CW-1:0] cnt_a,
  input logic [NCH-1:0][CW-1:0] cst_a
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic wr_cnt, clr_wr;
    assign wr_cnt = bus_sel && bus_wr && (bus_addr == AW'(((c + 1) << 2) | 0));
    assign clr_wr = bus_sel && bus_wr && (bus_addr == AW'(((c + 1) << 2) | 2))
                    && !bus_wdata[8];

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_v[c] && cnt_a[c] != '0 && !wr_cnt) |=> (cnt_a[c] == $past(cnt_a[c]) - 1'b1));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_v[c] && cnt_a[c] == '0 && !wr_cnt) |=> (cnt_a[c] == $past(cst_a[c])));

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_v[c] && cnt_a[c] == '0) |=> flag_v[c]);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v[c] && !clr_wr) |=> flag_v[c]);

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> flag_v[c]);

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_v[c] && !wr_cnt) |=> $stable(cnt_a[c]));

    p_tick_needs_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tick_v[c] |-> run_v[c]);
  end
endmodule

bind mtimer_unit mtu_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .run_v     (start_q),
  .tick_v    (tick_v),
  .flag_v    (flag_v),
  .cnt_a     (cnt_a),
  .cst_a     (cst_a)
);

// File: tb/test_mtimer_unit.sv
`timescale 1ns/1ps
module test_mtimer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mtimer_unit i_mtimer_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // vectors: {select, load value, constant}; all on channel 0
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{
    '{0, 0, 5}, '{1, 2, 7}, '{2, 1, 0}, '{3, 1, 9}, '{5, 3, 2}
  };

  function automatic logic [3:0] ad(input int slot, input int r);
    return 4'((slot << 2) | r);
  endfunction

  function automatic int period(input int sel);
    return (sel > 3) ? 4 : (4 << (2 * sel));
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1;
    v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(ad(0, 0), v); chk("R1 start", v, 32'h0);
    for (int c = 0; c < 3; c++) begin
      rd(ad(c + 1, 0), v); chk("R1 count", v, 32'hFFFF_FFFF);
      rd(ad(c + 1, 1), v); chk("R1 const", v, 32'hFFFF_FFFF);
      rd(ad(c + 1, 2), v); chk("R1 ctrl", v, 32'h0);
    end
    chk("R1 irq", {29'd0, irq}, 32'h0);

    // R3 R4 R5 vector table: underflow lands period*(L+1) edges after start
    for (int k = 0; k < NV; k++) begin
      wr(ad(0, 0), 32'h0);
      wr(ad(1, 2), 32'(VEC[k][0]));
      wr(ad(1, 0), 32'(VEC[k][1]));
      wr(ad(1, 1), 32'(VEC[k][2]));
      rd(ad(1, 0), v); chk("R3 count load", v, 32'(VEC[k][1]));
      wr(ad(0, 0), 32'h1);
      t = period(VEC[k][0]) * (VEC[k][1] + 1);
      wait_n(t - 1);
      rd(ad(1, 0), v); chk("R4 count before underflow", v, 32'h0);
      rd(ad(1, 2), v); chk("R5 flag before underflow", {31'd0, v[8]}, 32'h0);
      wait_n(1);
      rd(ad(1, 0), v); chk("R5 reload value", v, 32'(VEC[k][2]));
      rd(ad(1, 2), v); chk("R5 flag after underflow", {31'd0, v[8]}, 32'h1);
    end
    wr(ad(0, 0), 32'h0);

    // R2 R7 R8 flag write semantics and interrupt gating on channel 0 (flag set)
    wr(ad(1, 2), 32'h0000_0100);
    rd(ad(1, 2), v); chk("R7 write 1 keeps flag", v, 32'h0000_0100);
    wr(ad(1, 2), 32'h0000_0120);
    chk("R8 irq on", {29'd0, irq}, 32'h1);
    wr(ad(1, 2), 32'h0000_0100);
    chk("R8 irq off with enable 0", {29'd0, irq}, 32'h0);
    wr(ad(1, 2), 32'h0000_0000);
    rd(ad(1, 2), v); chk("R7 write 0 clears", v, 32'h0);

    // R7 collision and R6 one-shot on channel 1: const 0, load 0, divide 4
    rd(ad(1, 0), v2);
    wr(ad(2, 2), 32'h0);
    wr(ad(2, 0), 32'h0);
    wr(ad(2, 1), 32'h0);
    wr(ad(0, 0), 32'h2);
    wait_n(4);
    rd(ad(2, 2), v); chk("R5 ch1 flag", {31'd0, v[8]}, 32'h1);
    rd(ad(2, 0), v); chk("R6 one-shot stays 0", v, 32'h0);
    wr(ad(2, 2), 32'h0);
    rd(ad(2, 2), v); chk("R7 clear between underflows", {31'd0, v[8]}, 32'h0);
    wait_n(2);
    wr(ad(2, 2), 32'h0);
    rd(ad(2, 2), v); chk("R7 underflow beats clear", {31'd0, v[8]}, 32'h1);
    rd(ad(1, 0), v); chk("R9 channel 0 untouched", v, v2);
    wr(ad(0, 0), 32'h0);

    // R9 freeze on channel 2
    wr(ad(3, 2), 32'h0);
    wr(ad(3, 0), 32'd1000);
    wr(ad(0, 0), 32'h4);
    rd(ad(0, 0), v); chk("R2 start readback", v, 32'h4);
    wait_n(10);
    wr(ad(0, 0), 32'h0);
    rd(ad(3, 0), v); chk("R9 count at stop", v, 32'd998);
    wait_n(20);
    rd(ad(3, 0), v); chk("R9 count frozen", v, 32'd998);

    // R6 wrap with all-ones constant
    wr(ad(3, 0), 32'h0);
    wr(ad(3, 1), 32'hFFFF_FFFF);
    wr(ad(0, 0), 32'h4);
    wait_n(4);
    rd(ad(3, 0), v); chk("R6 wrap to all ones", v, 32'hFFFF_FFFF);
    wait_n(4);
    rd(ad(3, 0), v); chk("R6 continues down", v, 32'hFFFF_FFFE);
    wr(ad(0, 0), 32'h0);

    // R10 prescaler restart, divide 256
    wr(ad(3, 2), 32'h3);
    wr(ad(3, 0), 32'h0);
    wr(ad(3, 1), 32'h55);
    wr(ad(0, 0), 32'h4);
    wait_n(100);
    wr(ad(0, 0), 32'h0);
    wr(ad(0, 0), 32'h4);
    wait_n(255);
    rd(ad(3, 2), v); chk("R10 no early tick", {31'd0, v[8]}, 32'h0);
    wait_n(1);
    rd(ad(3, 2), v); chk("R10 tick after full period", {31'd0, v[8]}, 32'h1);
    rd(ad(3, 0), v); chk("R10 reload", v, 32'h55);
    wr(ad(0, 0), 32'h0);

    // R2 control field readback, reserved bits drop, writing bit 8 as 1 keeps flag 0
    wr(ad(3, 2), 32'h0);
    wr(ad(3, 2), 32'hFFFF_FFFF);
    rd(ad(3, 2), v); chk("R2 ctrl fields", v, 32'h0000_0027);
    chk("R8 irq low without flag", {29'd0, irq}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule